// File: doc/BRIEF.md
# Lock-Aware Set-Associative Tag and State Array

This block keeps the tags and coherence state for every line of a set-associative cache. It does not hold any line data. A cache controller uses two independent ports. The lookup port takes a byte address and returns in the same cycle whether the line is present, which way holds it and its state. At the next clock edge it refreshes the line's recency and, for a write, marks the line modified. The fill port takes a byte address and a target state. It chooses a way, reports in the same cycle the line it displaces, and installs the new tag at the edge.

An external miss-tracking unit lists the line addresses of its outstanding misses on a small lock vector. Victim selection never takes a way whose stored line address is on that list. If every way of a set is protected and none already holds the requested tag, the fill stalls. The controller holds the request until a way frees up. The block raises a writeback flag when a dirty line is displaced under write-back policy, and a forward flag on every write hit under write-through policy. Another unit acts on these flags.

The ways of one set are interleaved across the storage at a stride equal to the set count: way k of set s sits at slot s + k·2^SET_BITS. Recency comes from one shared timestamp counter, so every line carries an absolute age.

Top module: `lat_tag_array`

## Requirements
- R1: After reset every line is invalid. Any lookup misses, and the eviction count reads zero.
- R2: The set index is the address bits just above the OFFSET_BITS offset field. The tag is all address bits above the set index. Offset bits have no effect on lookups or fills.
- R3: A lookup hits only when a way of the addressed set holds the same tag in a state other than invalid. On a hit it reports that way and the state. State codes are 0 invalid, 1 shared, 2 exclusive, 3 modified.
- R4: A shared timestamp counter gives recency. A lookup hit stamps the line with the counter value and a completed fill stamps its line. The counter advances once for each. When both happen in one cycle, the lookup takes value T and the fill takes T+1.
- R5: A fill takes, in order: the lowest way whose stored tag equals the fill tag (regardless of state); else the lowest invalid unlocked way; else the unlocked way with the smallest timestamp, with the lower way winning a tie.
- R6: A way is locked when a valid lock entry equals its stored line address {tag, set}. A locked way is never taken by the invalid or oldest-way choices.
- R7: When no way matches the fill tag and every way of the set is locked, fl_stall is high, fl_done is low and no line changes.
- R8: When a fill displaces a valid line through the oldest-way choice, vic_valid is high. vic_line is the old tag followed by the set index, vic_state is the old state, and the eviction count rises by one at the edge.
- R9: A completed fill writes the requested state into the line. A write hit sets the line to modified (3).
- R10: With write-back policy, wb_req is high exactly when the reported victim is modified.
- R11: With write-through policy, wt_fwd is high on every write hit and wb_req stays low.
- R12: When a fill and a lookup hit address the same line in one cycle, the fill's tag, state and timestamp are the ones kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_req | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write |
| lk_addr | input | ADDR_W | Lookup byte address |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | WAY_W | Way that hit |
| lk_state | output | 2 | State of the hit line (0 on miss) |
| wt_fwd | output | 1 | Write hit to forward (write-through policy) |
| fl_req | input | 1 | Fill request |
| fl_addr | input | ADDR_W | Fill byte address |
| fl_state | input | 2 | State to install |
| fl_done | output | 1 | Fill is performed at this edge |
| fl_stall | output | 1 | Fill blocked, every way locked |
| fl_way | output | WAY_W | Way chosen for the fill |
| vic_valid | output | 1 | A valid line is displaced |
| vic_line | output | LINE_W | Line address of the displaced line |
| vic_state | output | 2 | State of the displaced line |
| wb_req | output | 1 | Displaced line needs writing back |
| lock_vld | input | LOCKS | Valid bit per lock entry |
| lock_line | input | LOCKS*LINE_W | Locked line addresses, entry i at bits i*LINE_W |
| evict_cnt | output | CNT_W | Number of displacements so far |

## Verification
The hardest case to reach is a fill stall. Every way of one set must hold a line whose address is on the lock list, and no way may already carry the requested tag. Random traffic almost never produces this. The bench builds it on purpose: it fills a set completely, loads all four of that set's line addresses into the lock entries, holds a fill to a fresh tag for several cycles, then frees one entry and expects the fill to land in exactly that way. A second version follows a fresh reset. The invalid lines still carry tag zero, so locking that one line address blocks every way. A fill of a new tag then stalls, while a fill of tag zero completes through the tag-match path.

// File: rtl/lat_pkg.sv
package lat_pkg;
  typedef logic [1:0] line_st_t;
  localparam line_st_t ST_INV = 2'd0;
  localparam line_st_t ST_SHR = 2'd1;
  localparam line_st_t ST_EXC = 2'd2;
  localparam line_st_t ST_MOD = 2'd3;
endpackage

// File: rtl/lat_line_store.sv
module lat_line_store
  import lat_pkg::*;
#(
  parameter int TAG_W  = 12,
  parameter int TS_W   = 32,
  parameter int SLOT_W = 4,
  localparam int NUM_LINES = 1 << SLOT_W
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               upd_en,
  input  logic [SLOT_W-1:0]                  upd_slot,
  input  line_st_t                           upd_state,
  input  logic [TS_W-1:0]                    upd_ts,
  input  logic                               fill_en,
  input  logic [SLOT_W-1:0]                  fill_slot,
  input  logic [TAG_W-1:0]                   fill_tag,
  input  line_st_t                           fill_state,
  input  logic [TS_W-1:0]                    fill_ts,
  output logic [NUM_LINES-1:0][TAG_W-1:0]    tag_q,
  output logic [NUM_LINES-1:0][1:0]          st_q,
  output logic [NUM_LINES-1:0][TS_W-1:0]     ts_q
);
  logic [NUM_LINES-1:0][TAG_W-1:0] tag_d;
  logic [NUM_LINES-1:0][1:0]       st_d;
  logic [NUM_LINES-1:0][TS_W-1:0]  ts_d;
  logic                            wr_en;

  assign wr_en = upd_en | fill_en;

  // lookup update first, fill second: a fill to the same slot wins
  always_comb begin
    tag_d = tag_q;
    st_d  = st_q;
    ts_d  = ts_q;
    if (upd_en) begin
      st_d[upd_slot] = upd_state;
      ts_d[upd_slot] = upd_ts;
    end
    if (fill_en) begin
      tag_d[fill_slot] = fill_tag;
      st_d[fill_slot]  = fill_state;
      ts_d[fill_slot]  = fill_ts;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      st_q  <= '0;
      ts_q  <= '0;
    end else if (wr_en) begin
      tag_q <= tag_d;
      st_q  <= st_d;
      ts_q  <= ts_d;
    end
  end
endmodule

// File: rtl/lat_lock_match.sv
module lat_lock_match #(
  parameter int WAYS   = 4,
  parameter int LINE_W = 14,
  parameter int LOCKS  = 4
) (
  input  logic [WAYS-1:0][LINE_W-1:0] way_line,
  input  logic [LOCKS-1:0]            lock_vld,
  input  logic [LOCKS*LINE_W-1:0]     lock_line,
  output logic [WAYS-1:0]             locked
);
  for (genvar k = 0; k < WAYS; k++) begin : g_way
    logic [LOCKS-1:0] hit_vec;
    for (genvar i = 0; i < LOCKS; i++) begin : g_ent
      assign hit_vec[i] = lock_vld[i] && (lock_line[i*LINE_W +: LINE_W] == way_line[k]);
    end
    assign locked[k] = |hit_vec;
  end
endmodule

// File: rtl/lat_victim_pick.sv
module lat_victim_pick #(
  parameter int WAYS = 4,
  parameter int TS_W = 32,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]            tag_eq,
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0]            locked,
  input  logic [WAYS-1:0][TS_W-1:0]  ts,
  output logic                       found,
  output logic [WAY_W-1:0]           way,
  output logic                       took_match,
  output logic                       took_lru
);
  logic             m_any, i_any, l_any;
  logic [WAY_W-1:0] m_way, i_way, l_way;
  logic [TS_W-1:0]  best;

  always_comb begin
    m_any = 1'b0; m_way = '0;
    i_any = 1'b0; i_way = '0;
    l_any = 1'b0; l_way = '0;
    best  = '0;
    for (int k = 0; k < WAYS; k++) begin
      if (tag_eq[k] && !m_any) begin
        m_any = 1'b1;
        m_way = WAY_W'(k);
      end
      if (!valid[k] && !locked[k] && !i_any) begin
        i_any = 1'b1;
        i_way = WAY_W'(k);
      end
      if (!locked[k] && (!l_any || (ts[k] < best))) begin
        l_any = 1'b1;
        l_way = WAY_W'(k);
        best  = ts[k];
      end
    end
  end

  assign found      = m_any | i_any | l_any;
  assign took_match = m_any;
  assign took_lru   = !m_any && !i_any && l_any;
  assign way        = m_any ? m_way : (i_any ? i_way : l_way);
endmodule

// File: rtl/lat_tag_array.sv
module lat_tag_array
  import lat_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int OFFSET_BITS = 2,
  parameter int SET_BITS    = 2,
  parameter int WAYS        = 4,
  parameter int LOCKS       = 4,
  parameter int TS_W        = 32,
  parameter int CNT_W       = 16,
  parameter bit WRITE_THROUGH = 1'b0,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TAG_W  = ADDR_W - OFFSET_BITS - SET_BITS,
  localparam int LINE_W = ADDR_W - OFFSET_BITS,
  localparam int SLOT_W = SET_BITS + WAY_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lk_req,
  input  logic                    lk_write,
  input  logic [ADDR_W-1:0]       lk_addr,
  output logic                    lk_hit,
  output logic [WAY_W-1:0]        lk_way,
  output logic [1:0]              lk_state,
  output logic                    wt_fwd,
  input  logic                    fl_req,
  input  logic [ADDR_W-1:0]       fl_addr,
  input  logic [1:0]              fl_state,
  output logic                    fl_done,
  output logic                    fl_stall,
  output logic [WAY_W-1:0]        fl_way,
  output logic                    vic_valid,
  output logic [LINE_W-1:0]       vic_line,
  output logic [1:0]              vic_state,
  output logic                    wb_req,
  input  logic [LOCKS-1:0]        lock_vld,
  input  logic [LOCKS*LINE_W-1:0] lock_line,
  output logic [CNT_W-1:0]        evict_cnt
);
  localparam int NUM_LINES = 1 << SLOT_W;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // address split
  logic [SET_BITS-1:0] lk_set, fl_set;
  logic [TAG_W-1:0]    lk_tag, fl_tag;
  logic                unused_offset;
  assign lk_set = lk_addr[OFFSET_BITS +: SET_BITS];
  assign fl_set = fl_addr[OFFSET_BITS +: SET_BITS];
  assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
  assign fl_tag = fl_addr[ADDR_W-1 -: TAG_W];
  assign unused_offset = ^{lk_addr[OFFSET_BITS-1:0], fl_addr[OFFSET_BITS-1:0]};

  // storage
  logic [NUM_LINES-1:0][TAG_W-1:0] tag_q;
  logic [NUM_LINES-1:0][1:0]       st_q;
  logic [NUM_LINES-1:0][TS_W-1:0]  ts_q;
  logic              upd_en, fill_en;
  logic [SLOT_W-1:0] upd_slot, fill_slot;
  line_st_t          upd_state;
  logic [TS_W-1:0]   upd_ts, fill_ts;
  logic [TS_W-1:0]   ts_cnt_q, ts_cnt_d;
  logic [CNT_W-1:0]  ev_cnt_q, ev_cnt_d;

  // per-way view of the two addressed sets (way k of set s at s + k<<SET_BITS)
  logic [WAYS-1:0]             lk_match;
  logic [WAYS-1:0]             fl_tag_eq, fl_valid, fl_locked;
  logic [WAYS-1:0][TS_W-1:0]   fl_ts;
  logic [WAYS-1:0][LINE_W-1:0] fl_line;
  logic [WAYS-1:0][1:0]        fl_way_st;

  for (genvar k = 0; k < WAYS; k++) begin : g_way
    localparam logic [WAY_W-1:0] KW = WAY_W'(k);
    logic [SLOT_W-1:0] ls, fs;
    assign ls           = {KW, lk_set};
    assign fs           = {KW, fl_set};
    assign lk_match[k]  = (tag_q[ls] == lk_tag) && (st_q[ls] != ST_INV);
    assign fl_tag_eq[k] = (tag_q[fs] == fl_tag);
    assign fl_valid[k]  = (st_q[fs] != ST_INV);
    assign fl_ts[k]     = ts_q[fs];
    assign fl_line[k]   = {tag_q[fs], fl_set};
    assign fl_way_st[k] = st_q[fs];
  end

  // lookup
  logic             lk_any;
  logic [WAY_W-1:0] lk_sel;
  always_comb begin
    lk_any = 1'b0;
    lk_sel = '0;
    for (int k = 0; k < WAYS; k++) begin
      if (lk_match[k] && !lk_any) begin
        lk_any = 1'b1;
        lk_sel = WAY_W'(k);
      end
    end
  end

  assign lk_hit   = lk_req && lk_any;
  assign lk_way   = lk_sel;
  assign lk_state = lk_hit ? st_q[{lk_sel, lk_set}] : ST_INV;
  assign wt_fwd   = WRITE_THROUGH && lk_hit && lk_write;

  // fill way choice
  logic             pick_found, pick_match, pick_lru;
  logic [WAY_W-1:0] pick_way;

  lat_lock_match #(.WAYS(WAYS), .LINE_W(LINE_W), .LOCKS(LOCKS)) u_lock (
    .way_line (fl_line),
    .lock_vld (lock_vld),
    .lock_line(lock_line),
    .locked   (fl_locked)
  );

  lat_victim_pick #(.WAYS(WAYS), .TS_W(TS_W)) u_pick (
    .tag_eq    (fl_tag_eq),
    .valid     (fl_valid),
    .locked    (fl_locked),
    .ts        (fl_ts),
    .found     (pick_found),
    .way       (pick_way),
    .took_match(pick_match),
    .took_lru  (pick_lru)
  );

  assign fl_done   = fl_req && pick_found;
  assign fl_stall  = fl_req && !pick_found;
  assign fl_way    = pick_way;
  assign vic_valid = fl_done && pick_lru;
  assign vic_line  = vic_valid ? fl_line[pick_way] : '0;
  assign vic_state = vic_valid ? fl_way_st[pick_way] : ST_INV;
  assign wb_req    = !WRITE_THROUGH && vic_valid && (vic_state == ST_MOD);

  // write controls and counters (next state)
  always_comb begin
    upd_en    = lk_hit;
    upd_slot  = {lk_sel, lk_set};
    upd_state = lk_write ? ST_MOD : line_st_t'(lk_state);
    upd_ts    = ts_cnt_q;
    fill_en   = fl_done;
    fill_slot = {pick_way, fl_set};
    fill_ts   = ts_cnt_q + TS_W'(lk_hit);
    ts_cnt_d  = ts_cnt_q + TS_W'(lk_hit) + TS_W'(fl_done);
    ev_cnt_d  = ev_cnt_q + CNT_W'(vic_valid);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ts_cnt_q <= '0;
      ev_cnt_q <= '0;
    end else begin
      if (lk_hit || fl_done) ts_cnt_q <= ts_cnt_d;
      if (vic_valid)         ev_cnt_q <= ev_cnt_d;
    end
  end

  assign evict_cnt = ev_cnt_q;

  lat_line_store #(.TAG_W(TAG_W), .TS_W(TS_W), .SLOT_W(SLOT_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .upd_en    (upd_en),
    .upd_slot  (upd_slot),
    .upd_state (upd_state),
    .upd_ts    (upd_ts),
    .fill_en   (fill_en),
    .fill_slot (fill_slot),
    .fill_tag  (fl_tag),
    .fill_state(line_st_t'(fl_state)),
    .fill_ts   (fill_ts),
    .tag_q     (tag_q),
    .st_q      (st_q),
    .ts_q      (ts_q)
  );

  // assertions
  assert_ts_advance_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (lk_hit || fl_done) |=> (ts_cnt_q != $past(ts_cnt_q)));

  assert_fill_skips_lock_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (fl_done && !pick_match) |-> !fl_locked[pick_way]);

  assert_stall_no_victim_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    fl_stall |-> (!vic_valid && !fl_done));

  assert_stall_keeps_count_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    fl_stall |=> $stable(evict_cnt));

  assert_evict_count_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    vic_valid |=> (evict_cnt == $past(evict_cnt) + CNT_W'(1)));

  assert_write_sets_mod_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (lk_hit && lk_write && !(fl_done && (fill_slot == upd_slot)))
      |=> (st_q[$past(upd_slot)] == ST_MOD));

  assert_wb_only_dirty_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    wb_req |-> (vic_valid && (vic_state == ST_MOD)));

  assert_fwd_on_write_hit_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    wt_fwd |-> (lk_hit && lk_write));
endmodule

// File: tb/lat_tag_array_bench.sv
`timescale 1ns/1ps
module lat_tag_array_bench;
  localparam int OFF = 2, SB = 2, WAYS = 4, LOCKS = 4;
  localparam int LINE_W = 14, NL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        lk_req = 0, lk_write = 0, fl_req = 0;
  logic [15:0] lk_addr = '0, fl_addr = '0;
  logic [1:0]  fl_state = '0;
  logic [LOCKS-1:0]        lkv = '0;
  logic [LOCKS*LINE_W-1:0] lkl = '0;

  logic        a_hit, a_wt, a_done, a_stall, a_vv, a_wb;
  logic [1:0]  a_way, a_st, a_fway, a_vst;
  logic [13:0] a_vl;
  logic [15:0] a_ev;
  logic        b_hit, b_wt, b_done, b_stall, b_vv, b_wb;
  logic [1:0]  b_way, b_st, b_fway, b_vst;
  logic [13:0] b_vl;
  logic [15:0] b_ev;

  lat_tag_array u_lat_tag_array (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_write(lk_write), .lk_addr(lk_addr),
    .lk_hit(a_hit), .lk_way(a_way), .lk_state(a_st), .wt_fwd(a_wt),
    .fl_req(fl_req), .fl_addr(fl_addr), .fl_state(fl_state), .fl_done(a_done),
    .fl_stall(a_stall), .fl_way(a_fway), .vic_valid(a_vv), .vic_line(a_vl),
    .vic_state(a_vst), .wb_req(a_wb), .lock_vld(lkv), .lock_line(lkl), .evict_cnt(a_ev));

  lat_tag_array #(.WRITE_THROUGH(1'b1)) u_lat_tag_array_wt (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_write(lk_write), .lk_addr(lk_addr),
    .lk_hit(b_hit), .lk_way(b_way), .lk_state(b_st), .wt_fwd(b_wt),
    .fl_req(fl_req), .fl_addr(fl_addr), .fl_state(fl_state), .fl_done(b_done),
    .fl_stall(b_stall), .fl_way(b_fway), .vic_valid(b_vv), .vic_line(b_vl),
    .vic_state(b_vst), .wb_req(b_wb), .lock_vld(lkv), .lock_line(lkl), .evict_cnt(b_ev));

  int n_chk = 0, n_err = 0;
  int m_tag[NL];
  int m_st[NL];
  longint m_ts[NL];
  longint m_cnt;
  int m_ev;
  // values sampled in the last cycle, for directed checks
  int s_hit, s_way, s_st, s_fway, s_done, s_stall, s_vv, s_vl, s_vst, s_wb, s_wbt, s_wt;

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(int tag, int set, int off);
    return 16'((tag << (OFF + SB)) | (set << OFF) | off);
  endfunction

  function automatic bit is_locked(int line);
    for (int i = 0; i < LOCKS; i++)
      if (lkv[i] && (int'(lkl[i*LINE_W +: LINE_W]) == line)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NL; i++) begin m_tag[i] = 0; m_st[i] = 0; m_ts[i] = 0; end
    m_cnt = 0; m_ev = 0;
  endtask

  task automatic cyc(bit lr, bit lw, logic [15:0] la, bit fr, logic [15:0] fa, logic [1:0] fs);
    int ls, lt, fset, ft, e_way, e_st, f_way, path, sl, fsl;
    bit e_hit, f_done, vv, anyl;
    longint best;
    @(negedge clk);
    lk_req = lr; lk_write = lw; lk_addr = la; fl_req = fr; fl_addr = fa; fl_state = fs;
    #2;
    ls = (int'(la) >> OFF) & 3; lt = int'(la) >> (OFF + SB);
    fset = (int'(fa) >> OFF) & 3; ft = int'(fa) >> (OFF + SB);
    e_hit = 0; e_way = 0; e_st = 0;
    for (int k = 0; k < WAYS; k++) begin
      sl = ls + (k << SB);
      if (!e_hit && m_st[sl] != 0 && m_tag[sl] == lt) begin e_hit = 1; e_way = k; e_st = m_st[sl]; end
    end
    e_hit = e_hit && lr;
    path = 0; f_way = 0; anyl = 0; best = 0;
    for (int k = 0; k < WAYS; k++)
      if (path == 0 && m_tag[fset + (k << SB)] == ft) begin path = 1; f_way = k; end
    for (int k = 0; k < WAYS; k++) begin
      sl = fset + (k << SB);
      if (path == 0 && m_st[sl] == 0 && !is_locked((m_tag[sl] << SB) | fset)) begin path = 2; f_way = k; end
    end
    for (int k = 0; k < WAYS; k++) begin
      sl = fset + (k << SB);
      if (path == 0 && !is_locked((m_tag[sl] << SB) | fset) && (!anyl || m_ts[sl] < best)) begin
        anyl = 1; best = m_ts[sl]; f_way = k;
      end
    end
    if (path == 0 && anyl) path = 3;
    f_done = fr && path != 0;
    vv = f_done && path == 3;
    fsl = fset + (f_way << SB);
    s_hit = int'(a_hit); s_way = int'(a_way); s_st = int'(a_st); s_fway = int'(a_fway);
    s_done = int'(a_done); s_stall = int'(a_stall); s_vv = int'(a_vv); s_vl = int'(a_vl);
    s_vst = int'(a_vst); s_wb = int'(a_wb); s_wbt = int'(b_wb); s_wt = int'(b_wt);
    chk("R3", "lk_hit", a_hit, e_hit);
    chk("R3", "lk_hit wt", b_hit, e_hit);
    if (e_hit) begin
      chk("R3", "lk_way", a_way, e_way);
      chk("R3", "lk_state", a_st, e_st);
    end
    chk("R11", "wt_fwd wt", b_wt, e_hit && lw);
    chk("R10", "wt_fwd wb", a_wt, 0);
    if (fr) begin
      chk("R5", "fl_done", a_done, f_done);
      chk("R7", "fl_stall", a_stall, !f_done);
      chk("R5", "fl_done wt", b_done, f_done);
      if (f_done) chk("R5", "fl_way", a_fway, f_way);
      chk("R8", "vic_valid", a_vv, vv);
      if (vv) begin
        chk("R8", "vic_line", a_vl, (m_tag[fsl] << SB) | fset);
        chk("R8", "vic_state", a_vst, m_st[fsl]);
      end
      chk("R10", "wb_req", a_wb, vv && m_st[fsl] == 3);
      chk("R11", "wb_req wt", b_wb, 0);
    end
    chk("R8", "evict_cnt", a_ev, m_ev);
    // model update at the edge (R4, R9, R12)
    if (e_hit) begin
      sl = ls + (e_way << SB);
      m_ts[sl] = m_cnt; m_cnt++;
      if (lw) m_st[sl] = 3;
    end
    if (f_done) begin
      m_tag[fsl] = ft; m_st[fsl] = int'(fs); m_ts[fsl] = m_cnt; m_cnt++;
      if (vv) m_ev++;
    end
    @(posedge clk); #1;
    lk_req = 0; fl_req = 0; lk_write = 0;
  endtask

  task automatic idle(); cyc(0, 0, '0, 0, '0, 2'd0); endtask
  task automatic look(logic [15:0] a, bit w); cyc(1, w, a, 0, '0, 2'd0); endtask
  task automatic fill(logic [15:0] a, logic [1:0] s); cyc(0, 0, '0, 1, a, s); endtask

  task automatic set_lock(int i, bit v, int line);
    lkv[i] = v;
    lkl[i*LINE_W +: LINE_W] = 14'(line);
  endtask

  task automatic do_reset();
    lkv = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    model_clear();
  endtask

  bit finished = 0;
  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rnd;
    do_reset();
    // R1: everything misses after reset
    for (int s = 0; s < 4; s++) begin
      look(mk(s + 1, s, 0), 0);
      chk("R1", "hit after reset", s_hit, 0);
    end
    chk("R1", "evict_cnt after reset", a_ev, 0);

    // R5: fills go to the lowest invalid way; lookup of the previous line in the same cycle
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < WAYS; k++) begin
        cyc(k > 0, 0, mk(s * 4 + k, s, 1), 1, mk(s * 4 + k + 1, s, k), 2'd1);
        chk("R5", "invalid way order", s_fway, k);
        chk("R8", "no victim on empty way", s_vv, 0);
      end

    // R2, R3: every line hits, whatever the offset bits
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < WAYS; k++) begin
        look(mk(s * 4 + k + 1, s, 3 - k), 0);
        chk("R2", "hit ignoring offset", s_hit, 1);
        chk("R3", "way of hit", s_way, k);
        chk("R3", "shared state", s_st, 1);
      end
    look(mk(100, 0, 0), 0);
    chk("R3", "unknown tag misses", s_hit, 0);

    // R4: touch way 0 of set 1, the oldest is then way 1 (tag 6)
    look(mk(5, 1, 0), 0);
    fill(mk(20, 1, 0), 2'd1);
    chk("R4", "oldest way chosen", s_fway, 1);
    chk("R8", "victim line", s_vl, (6 << SB) | 1);
    chk("R8", "evict_cnt after edge", a_ev, 1);

    // R9, R10, R11: write hit, then evict the dirty line
    look(mk(9, 2, 0), 1);
    chk("R11", "forward on write hit", s_wt, 1);
    look(mk(9, 2, 0), 0);
    chk("R9", "write makes modified", s_st, 3);
    look(mk(10, 2, 0), 0); look(mk(11, 2, 0), 0); look(mk(12, 2, 0), 0);
    fill(mk(30, 2, 0), 2'd1);
    chk("R10", "dirty victim way", s_fway, 0);
    chk("R10", "wb_req write-back", s_wb, 1);
    chk("R11", "wb_req write-through", s_wbt, 0);
    chk("R8", "dirty victim line", s_vl, (9 << SB) | 2);

    // R6: lock the two oldest lines of set 3
    set_lock(0, 1, (13 << SB) | 3);
    set_lock(1, 1, (14 << SB) | 3);
    fill(mk(40, 3, 0), 2'd1);
    chk("R6", "locked ways skipped", s_fway, 2);
    chk("R6", "victim is oldest unlocked", s_vl, (15 << SB) | 3);

    // R7: every line of set 3 locked
    set_lock(2, 1, (40 << SB) | 3);
    set_lock(3, 1, (16 << SB) | 3);
    for (int i = 0; i < 3; i++) begin
      fill(mk(41, 3, 0), 2'd1);
      chk("R7", "stall while locked", s_stall, 1);
    end
    look(mk(16, 3, 0), 0);
    chk("R7", "stalled fill changed nothing", s_hit, 1);
    set_lock(3, 0, 0);
    fill(mk(41, 3, 0), 2'd1);
    chk("R7", "released way taken", s_fway, 3);

    // R5, R12: tag-match fill ignores locks and wins over a same-cycle lookup
    cyc(1, 0, mk(13, 3, 0), 1, mk(13, 3, 2), 2'd2);
    chk("R5", "tag match way", s_fway, 0);
    chk("R5", "tag match no victim", s_vv, 0);
    look(mk(13, 3, 0), 0);
    chk("R12", "fill state kept", s_st, 2);
    lkv = '0;

    // mixed traffic against the bench model
    rnd = 32'h1234_5678;
    for (int n = 0; n < 1500; n++) begin
      rnd ^= rnd << 13; rnd ^= rnd >> 17; rnd ^= rnd << 5;
      if ((n % 16) == 0)
        for (int i = 0; i < LOCKS; i++)
          set_lock(i, rnd[i], ((int'(rnd[8 + i*3 +: 3]) + 1) << SB) | ((int'(rnd[20 + i*2 +: 2]))));
      cyc(rnd[0], rnd[1] & rnd[2], mk(int'(rnd[5:3]) + 1, int'(rnd[7:6]), int'(rnd[9:8])),
          rnd[10], mk(int'(rnd[13:11]) + 1, int'(rnd[15:14]), int'(rnd[17:16])),
          rnd[18] ? 2'd2 : 2'd1);
    end

    // R6, R7 after reset: invalid lines still carry tag 0
    do_reset();
    set_lock(0, 1, 0);
    fill(mk(9, 0, 0), 2'd1);
    chk("R6", "locked invalid ways not used", s_stall, 1);
    fill(mk(0, 0, 0), 2'd1);
    chk("R5", "tag zero matches way 0", s_fway, 0);
    chk("R5", "tag zero done", s_done, 1);
    idle();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule